// File: doc/BRIEF.md
# Gate Schedule List Compiler

The block turns a gate-control schedule request into the shadow list image that a time-aware transmit scheduler reads. A request arrives as a start pulse that carries the number of schedule entries, the cycle time and a flag asking for cycle time extension. The entries follow one per cycle, each an 8-bit queue gate mask and a 32-bit interval. The block validates the whole request before it writes anything. It turns the intervals into cumulative window end times and stretches the last window to the cycle time. It then writes the mask, the end time and a per-queue gate-close time row for every window, and fills the unused window slots with zeros.

Image words leave through a registered write port as a region code, an index and a 32-bit data word. After reset the block also writes the per-queue maximum frame size table with its default value. Completion is reported as a one-cycle `done` pulse and failure as a one-cycle `fail` pulse. Both come with a status code that holds until the next result.

Top module: `gate_list_compiler`

## Requirements
- R1: After reset the block writes region 3 (maximum frame size table) at indices 0 to 7 with the value 2048 and issues no other write. It then lowers `busy`. While in reset, `done`, `fail` and `wr_en` are low and `status` is 0.
- R2: A start with `req_ext` set is rejected with status 3 and one `fail` pulse, and no write is issued. This check comes before the count check.
- R3: A start whose entry count is 0 or greater than 16 is rejected with status 1 and one `fail` pulse, and no write is issued.
- R4: An entry with a zero interval aborts the request with status 2 and one `fail` pulse. No shadow list word is written, and the entries still streamed after the abort are ignored.
- R5: When the running sum of intervals does not fit in 32 bits, the request aborts with status 4 and one `fail` pulse, and nothing is written.
- R6: Region 1 (end times), index k, holds the sum of intervals 0 through k for every window except the last. The last window holds the cycle time.
- R7: Region 0 (masks), index k, holds the gate mask of entry k in bits 7:0 for every window below the entry count.
- R8: For each slot from the entry count up to 15, region 0 and region 1 are written with 0.
- R9: Region 2 (close times), index 8*k+q, holds the end time of window k if bit q of its mask is set and 0 otherwise. It is written only for windows below the entry count.
- R10: A valid request ends in exactly one `done` pulse with status 0, never with `fail` in the same cycle. Exactly 32 + 8*count writes come before or in the `done` cycle.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a request when the block is idle |
| req_count | input | 5 | Number of schedule entries |
| req_cycle | input | 32 | Cycle time |
| req_ext | input | 1 | Cycle time extension requested |
| ent_valid | input | 1 | Entry present this cycle |
| ent_mask | input | 8 | Gate mask, bit q opens queue q |
| ent_interval | input | 32 | Window interval |
| busy | output | 1 | High outside the idle state |
| wr_en | output | 1 | Image write strobe |
| wr_kind | output | 2 | Region: 0 mask, 1 end time, 2 close time, 3 frame size limit |
| wr_idx | output | 7 | Index within the region |
| wr_data | output | 32 | Word written |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle rejection pulse |
| status | output | 3 | 0 ok, 1 bad count, 2 zero interval, 3 extension, 4 overflow |

## Verification
The bench goes after count edges: 1, 16, 0, 17 and 31 entries. A design that compared the count off by one would accept 17 entries or reject 16. It also tests a zero interval in the last position after earlier valid entries. A design that wrote windows as they streamed in would leave a partial image there. Two overflow cases are tested: a single interval of all ones, which is legal, and the same interval followed by 1, which must fail. A carry check that is one bit short fails either case. A start with extension requested together with count 0 must report the extension code. A stray start during the write phase must not produce a spurious `fail`. Random masks and intervals check that the close-time rows follow the mask bits exactly and that unused rows are never touched.

// File: rtl/glc_pkg.sv
`timescale 1ns/1ps
package glc_pkg;
  typedef enum logic [1:0] {
    WK_MASK  = 2'd0,
    WK_END   = 2'd1,
    WK_CLOSE = 2'd2,
    WK_SDU   = 2'd3
  } wr_kind_e;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_BAD_COUNT = 3'd1,
    ST_ZERO_IV   = 3'd2,
    ST_NO_EXT    = 3'd3,
    ST_OVERFLOW  = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    S_INIT = 2'd0,
    S_IDLE = 2'd1,
    S_RECV = 2'd2,
    S_EMIT = 2'd3
  } fsm_e;
endpackage

// File: rtl/gl_accum.sv
`timescale 1ns/1ps
// Running interval sum with a carry bit for overflow detection.
module gl_accum #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [TW-1:0] iv,
  output logic [TW:0]   sum_nxt
);
  logic [TW-1:0] sum_q;

  assign sum_nxt = {1'b0, sum_q} + {1'b0, iv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum_q <= '0;
    else if (clr) sum_q <= '0;
    else if (add) sum_q <= sum_nxt[TW-1:0];
  end
endmodule

// File: rtl/gl_store.sv
`timescale 1ns/1ps
// Per-window buffer: holds validated masks and end times until emission.
module gl_store #(
  parameter int N_SLOTS = 16,
  parameter int N_Q     = 8,
  parameter int TW      = 32,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] widx,
  input  logic [N_Q-1:0]    wmask,
  input  logic [TW-1:0]     wend,
  input  logic [SLOT_W-1:0] ridx,
  output logic [N_Q-1:0]    rmask,
  output logic [TW-1:0]     rend
);
  logic [N_Q-1:0] mask_v [N_SLOTS];
  logic [TW-1:0]  end_v  [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [N_Q-1:0] m_q;
    logic [TW-1:0]  e_q;
    always_ff @(posedge clk) begin
      if (we && (widx == SLOT_W'(s))) begin
        m_q <= wmask;
        e_q <= wend;
      end
    end
    assign mask_v[s] = m_q;
    assign end_v[s]  = e_q;
  end

  assign rmask = mask_v[ridx];
  assign rend  = end_v[ridx];
endmodule

// File: rtl/gl_emit.sv
`timescale 1ns/1ps
// Write sequencer: default frame size table after reset, then the shadow image.
module gl_emit
  import glc_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int N_Q     = 8,
  parameter int TW      = 32,
  parameter int SDU_DEF = 2048,
  localparam int SLOT_W = $clog2(N_SLOTS),
  localparam int CNT_W  = SLOT_W + 1,
  localparam int Q_W    = $clog2(N_Q),
  localparam int SUB_W  = $clog2(N_Q + 2),
  localparam int IDX_W  = $clog2(N_SLOTS * N_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_act,
  input  logic              emit_act,
  input  logic [CNT_W-1:0]  n_valid,
  input  logic [N_Q-1:0]    rmask,
  input  logic [TW-1:0]     rend,
  output logic [SLOT_W-1:0] ridx,
  output logic              last,
  output logic              wr_en,
  output logic [1:0]        wr_kind,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TW-1:0]     wr_data
);
  logic [SLOT_W-1:0] pos_q;
  logic [SUB_W-1:0]  sub_q;
  logic [Q_W-1:0]    q;
  logic              live, step_end, act;
  wr_kind_e          kind_n;
  logic [IDX_W-1:0]  idx_n;
  logic [TW-1:0]     data_n;

  assign act  = init_act | emit_act;
  assign ridx = pos_q;
  assign live = ({1'b0, pos_q} < n_valid);
  assign q    = Q_W'(sub_q - SUB_W'(2));

  always_comb begin
    if (init_act)  step_end = (sub_q == SUB_W'(N_Q - 1));
    else if (live) step_end = (sub_q == SUB_W'(N_Q + 1));
    else           step_end = (sub_q == SUB_W'(1));
    last = (init_act & step_end) |
           (emit_act & step_end & (pos_q == SLOT_W'(N_SLOTS - 1)));
  end

  always_comb begin
    kind_n = WK_SDU;
    idx_n  = IDX_W'(sub_q);
    data_n = TW'(SDU_DEF);
    if (!init_act) begin
      case (sub_q)
        SUB_W'(0): begin
          kind_n = WK_MASK;
          idx_n  = IDX_W'(pos_q);
          data_n = live ? TW'(rmask) : '0;
        end
        SUB_W'(1): begin
          kind_n = WK_END;
          idx_n  = IDX_W'(pos_q);
          data_n = live ? rend : '0;
        end
        default: begin
          kind_n = WK_CLOSE;
          idx_n  = IDX_W'(pos_q) * IDX_W'(N_Q) + IDX_W'(q);
          data_n = rmask[q] ? rend : '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sub_q <= '0;
    end else if (act) begin
      if (step_end) begin
        sub_q <= '0;
        pos_q <= pos_q + SLOT_W'(1);
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end else begin
      pos_q <= '0;
      sub_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_kind <= '0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= act;
      if (act) begin
        wr_kind <= kind_n;
        wr_idx  <= idx_n;
        wr_data <= data_n;
      end
    end
  end
endmodule

// File: rtl/gate_list_compiler.sv
`timescale 1ns/1ps
module gate_list_compiler
  import glc_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int N_Q     = 8,
  parameter int TW      = 32,
  parameter int SDU_DEF = 2048,
  localparam int SLOT_W = $clog2(N_SLOTS),
  localparam int CNT_W  = SLOT_W + 1,
  localparam int IDX_W  = $clog2(N_SLOTS * N_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_count,
  input  logic [TW-1:0]    req_cycle,
  input  logic             req_ext,
  input  logic             ent_valid,
  input  logic [N_Q-1:0]   ent_mask,
  input  logic [TW-1:0]    ent_interval,
  output logic             busy,
  output logic             wr_en,
  output logic [1:0]       wr_kind,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TW-1:0]    wr_data,
  output logic             done,
  output logic             fail,
  output logic [2:0]       status
);
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  fsm_e             st_q, st_n;
  logic [CNT_W-1:0] n_q, n_n, rcv_q, rcv_n;
  logic [TW-1:0]    cyc_q, cyc_n;
  logic             done_q, done_n, fail_q, fail_n;
  logic [2:0]       stat_q, stat_n;
  logic             acc_clr, acc_add, st_we, last_ent, emit_last;
  logic [TW:0]      sum_nxt;
  logic [TW-1:0]    wend;
  logic [SLOT_W-1:0] ridx;
  logic [N_Q-1:0]   rmask;
  logic [TW-1:0]    rend;

  assign last_ent = (rcv_q == n_q - CNT_W'(1));
  assign wend     = last_ent ? cyc_q : sum_nxt[TW-1:0];

  always_comb begin
    st_n    = st_q;
    n_n     = n_q;
    cyc_n   = cyc_q;
    rcv_n   = rcv_q;
    done_n  = 1'b0;
    fail_n  = 1'b0;
    stat_n  = stat_q;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    st_we   = 1'b0;
    case (st_q)
      S_INIT: if (emit_last) st_n = S_IDLE;
      S_IDLE: begin
        if (start) begin
          if (req_ext) begin
            fail_n = 1'b1;
            stat_n = ST_NO_EXT;
          end else if (req_count == '0 || req_count > CNT_W'(N_SLOTS)) begin
            fail_n = 1'b1;
            stat_n = ST_BAD_COUNT;
          end else begin
            st_n    = S_RECV;
            n_n     = req_count;
            cyc_n   = req_cycle;
            rcv_n   = '0;
            acc_clr = 1'b1;
          end
        end
      end
      S_RECV: begin
        if (ent_valid) begin
          if (ent_interval == '0) begin
            fail_n = 1'b1;
            stat_n = ST_ZERO_IV;
            st_n   = S_IDLE;
          end else if (sum_nxt[TW]) begin
            fail_n = 1'b1;
            stat_n = ST_OVERFLOW;
            st_n   = S_IDLE;
          end else begin
            acc_add = 1'b1;
            st_we   = 1'b1;
            rcv_n   = rcv_q + CNT_W'(1);
            if (last_ent) st_n = S_EMIT;
          end
        end
      end
      S_EMIT: begin
        if (emit_last) begin
          done_n = 1'b1;
          stat_n = ST_OK;
          st_n   = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= S_INIT;
      n_q    <= '0;
      cyc_q  <= '0;
      rcv_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      stat_q <= ST_OK;
    end else begin
      st_q   <= st_n;
      n_q    <= n_n;
      cyc_q  <= cyc_n;
      rcv_q  <= rcv_n;
      done_q <= done_n;
      fail_q <= fail_n;
      stat_q <= stat_n;
    end
  end

  gl_accum #(.TW(TW)) u_accum (
    .clk(clk), .rst_n(rst_sn), .clr(acc_clr), .add(acc_add),
    .iv(ent_interval), .sum_nxt(sum_nxt)
  );

  gl_store #(.N_SLOTS(N_SLOTS), .N_Q(N_Q), .TW(TW)) u_store (
    .clk(clk), .we(st_we), .widx(rcv_q[SLOT_W-1:0]), .wmask(ent_mask),
    .wend(wend), .ridx(ridx), .rmask(rmask), .rend(rend)
  );

  gl_emit #(.N_SLOTS(N_SLOTS), .N_Q(N_Q), .TW(TW), .SDU_DEF(SDU_DEF)) u_emit (
    .clk(clk), .rst_n(rst_sn), .init_act(st_q == S_INIT), .emit_act(st_q == S_EMIT),
    .n_valid(n_q), .rmask(rmask), .rend(rend), .ridx(ridx), .last(emit_last),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  assign busy   = (st_q != S_IDLE);
  assign done   = done_q;
  assign fail   = fail_q;
  assign status = stat_q;
endmodule

// File: rtl/glc_chk.sv
`timescale 1ns/1ps
module glc_chk #(
  parameter int TW      = 32,
  parameter int SDU_DEF = 2048
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wr_en,
  input logic [1:0]    wr_kind,
  input logic [TW-1:0] wr_data,
  input logic          done,
  input logic          fail,
  input logic [2:0]    status
);
  AST_SDU_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd3) |-> wr_data == TW'(SDU_DEF)); // R1
  AST_FAIL_NO_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !wr_en); // R2
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> status != 3'd0); // R3
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !wr_en); // R4
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R10
  AST_DONE_STATUS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'd0 && !busy)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind gate_list_compiler glc_chk #(.TW(TW), .SDU_DEF(SDU_DEF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_data(wr_data), .done(done), .fail(fail), .status(status)
);

// File: tb/gate_list_compiler_tb.sv
`timescale 1ns/1ps
module gate_list_compiler_tb;
  localparam int NS = 16;
  localparam int NQ = 8;
  localparam logic [31:0] SENT = 32'hA5A5_A5A5;

  logic        clk = 1'b0;
  logic        rst_n, start, req_ext, ent_valid;
  logic [4:0]  req_count;
  logic [31:0] req_cycle, ent_interval, wr_data;
  logic [7:0]  ent_mask;
  logic        busy, wr_en, done, fail;
  logic [1:0]  wr_kind;
  logic [6:0]  wr_idx;
  logic [2:0]  status;

  always #2 clk = ~clk;

  gate_list_compiler u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
    .req_cycle(req_cycle), .req_ext(req_ext), .ent_valid(ent_valid),
    .ent_mask(ent_mask), .ent_interval(ent_interval), .busy(busy),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .fail(fail), .status(status)
  );

  logic [31:0] m_mask [NS];
  logic [31:0] m_end  [NS];
  logic [31:0] m_close[NS*NQ];
  logic [31:0] m_sdu  [NQ];
  int wr_cnt = 0, done_cnt = 0, fail_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0]  e_mask[NS];
  logic [31:0] e_iv  [NS];

  always @(negedge clk) begin
    if (wr_en) begin
      wr_cnt++;
      case (wr_kind)
        2'd0: m_mask[wr_idx[3:0]] = wr_data;
        2'd1: m_end[wr_idx[3:0]] = wr_data;
        2'd2: m_close[wr_idx] = wr_data;
        default: m_sdu[wr_idx[2:0]] = wr_data;
      endcase
    end
    if (done) done_cnt++;
    if (fail) fail_cnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NS; i++) begin m_mask[i] = SENT; m_end[i] = SENT; end
    for (int i = 0; i < NS*NQ; i++) m_close[i] = SENT;
    wr_cnt = 0; done_cnt = 0; fail_cnt = 0;
  endtask

  task automatic fill_rand(input int n, input int unsigned maxiv);
    for (int k = 0; k < n; k++) begin
      e_mask[k] = 8'($urandom);
      e_iv[k]   = 1 + ($urandom % maxiv);
    end
  endtask

  task automatic run(input int n, input int n_stream, input logic [31:0] cyc,
                     input bit ext, input bit poke);
    logic [31:0] xe[NS];
    longint s = 0;
    int st = 0, t = 0;
    string lbl;
    if (ext) st = 3;
    else if (n == 0 || n > NS) st = 1;
    else begin
      for (int k = 0; k < n; k++) begin
        if (e_iv[k] == 0) begin st = 2; break; end
        s += longint'(e_iv[k]);
        if (s > 64'h0000_0000_FFFF_FFFF) begin st = 4; break; end
        xe[k] = (k == n - 1) ? cyc : s[31:0];
      end
    end
    case (st)
      0: lbl = "R10"; 1: lbl = "R3"; 2: lbl = "R4"; 3: lbl = "R2"; default: lbl = "R5";
    endcase
    while (busy) @(negedge clk);
    @(negedge clk);
    clear_model();
    start = 1'b1; req_count = 5'(n); req_cycle = cyc; req_ext = ext;
    @(negedge clk);
    start = 1'b0; req_ext = 1'b0;
    for (int k = 0; k < n_stream; k++) begin
      ent_valid = 1'b1; ent_mask = e_mask[k]; ent_interval = e_iv[k];
      @(negedge clk);
    end
    ent_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; req_ext = 1'b1; req_count = 5'd0;
      @(negedge clk);
      start = 1'b0; req_ext = 1'b0;
    end
    while (done_cnt == 0 && fail_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(status == 3'(st), lbl, status, st);
    if (st == 0) begin
      chk(done_cnt == 1 && fail_cnt == 0, poke ? "R11 no stray fail" : "R10 one done",
          fail_cnt, 0);
      chk(wr_cnt == 2*NS + NQ*n, "R10 write count", wr_cnt, 2*NS + NQ*n);
      for (int k = 0; k < NS; k++) begin
        if (k < n) begin
          chk(m_mask[k] == {24'd0, e_mask[k]}, "R7 mask", m_mask[k], e_mask[k]);
          chk(m_end[k] == xe[k], "R6 end time", m_end[k], xe[k]);
          for (int q = 0; q < NQ; q++) begin
            logic [31:0] xc;
            xc = e_mask[k][q] ? xe[k] : 32'd0;
            chk(m_close[k*NQ+q] == xc, "R9 close time", m_close[k*NQ+q], xc);
          end
        end else begin
          chk(m_mask[k] == 0 && m_end[k] == 0, "R8 unused slot", m_end[k], 0);
          for (int q = 0; q < NQ; q++)
            chk(m_close[k*NQ+q] == SENT, "R9 unused row untouched", m_close[k*NQ+q], SENT);
        end
      end
    end else begin
      chk(fail_cnt == 1 && done_cnt == 0, lbl, fail_cnt, 1);
      chk(wr_cnt == 0, lbl, wr_cnt, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd917));
    for (int q = 0; q < NQ; q++) m_sdu[q] = SENT;
    rst_n = 1'b0; start = 1'b0; req_count = '0; req_cycle = '0; req_ext = 1'b0;
    ent_valid = 1'b0; ent_mask = '0; ent_interval = '0;
    repeat (4) @(negedge clk);
    chk(!done && !fail && !wr_en && status == 0, "R1 reset outputs",
        {done, fail, wr_en, status}, 0);
    rst_n = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(wr_cnt == NQ, "R1 init write count", wr_cnt, NQ);
    for (int q = 0; q < NQ; q++) chk(m_sdu[q] == 32'd2048, "R1 frame size default", m_sdu[q], 2048);

    // directed count edges
    fill_rand(NS, 5000);
    run(NS, NS, 32'd1_000_000, 1'b0, 1'b0);
    fill_rand(1, 5000);
    run(1, 1, 32'd777, 1'b0, 1'b0);
    run(0, 0, 32'd100, 1'b0, 1'b0);
    run(17, 0, 32'd100, 1'b0, 1'b0);
    run(31, 0, 32'd100, 1'b0, 1'b0);
    // extension rejected, and takes precedence over a bad count
    run(4, 0, 32'd100, 1'b1, 1'b0);
    run(0, 0, 32'd100, 1'b1, 1'b0);
    // zero interval in the last position, then in the middle with trailing entries
    fill_rand(5, 100); e_iv[4] = 0;
    run(5, 5, 32'd5000, 1'b0, 1'b0);
    fill_rand(8, 100); e_iv[2] = 0;
    run(8, 8, 32'd5000, 1'b0, 1'b0);
    // overflow boundary
    e_mask[0] = 8'hFF; e_iv[0] = 32'hFFFF_FFFF;
    run(1, 1, 32'h1234, 1'b0, 1'b0);
    e_mask[0] = 8'h0F; e_iv[0] = 32'hFFFF_FFFF; e_mask[1] = 8'hF0; e_iv[1] = 32'd1;
    run(2, 2, 32'h1234, 1'b0, 1'b0);
    // start while busy is ignored
    fill_rand(6, 1000);
    run(6, 6, 32'd9000, 1'b0, 1'b1);
    // random valid requests
    for (int r = 0; r < 40; r++) begin
      int n;
      n = 1 + int'($urandom % NS);
      fill_rand(n, 200000);
      run(n, n, $urandom, 1'b0, 1'b0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule